// File: doc/BRIEF.md
# Display Identification Stream Port

This block is the monitor-side identification port of a dual-mode serial memory. Out of reset it plays the whole contents of a byte array onto an open-drain data line, one bit per rising edge of a slow external stream clock. The first nine edges form a silent synchronization preamble with the line released. After the preamble, each byte is sent as eight data bits, most significant first, followed by a released null bit. Playback runs in ascending address order and wraps from the last location back to location 0 without a gap.

A separate bidirectional bus clock input is watched during streaming and is expected to stay high. A filtered high-to-low edge on it ends streaming for good. The line is released, a mode flag hands the data line to a two-wire slave outside this block, and the stream clock input then serves only as a write-enable level. Only a reset brings streaming back. Both clock inputs pass through a two-flop synchronizer and a hold filter in the system clock domain, so short spikes are rejected. The array is read through a registered address port, and the addressed byte has been stable for many system cycles before its first bit is launched.

Top module: `ddc_stream_port`

## Requirements
- R1: After reset the line is released (`sda_pull_low_o` = 0), `bidir_mode_o` = 0, `write_enable_o` = 0 and `rd_addr_o` = 0.
- R2: During the first nine accepted rising edges of the stream clock the line stays released.
- R3: The tenth accepted rising edge launches bit 7 of the byte at address 0, and each following edge launches the next lower bit. A data bit of 0 is shown as `sda_pull_low_o` = 1, and a data bit of 1 as `sda_pull_low_o` = 0. The line changes only after an accepted edge on one of the two clock inputs.
- R4: After bit 0 of a byte, the next edge gives a null slot with the line released. The edge after that launches bit 7 of the next byte.
- R5: Bytes are sent in ascending address order. After address DEPTH-1 playback continues with address 0, with no extra slot between them.
- R6: A level on either clock input that holds for fewer than FILT_CYC system clocks is ignored. It neither advances the stream nor causes the handover.
- R7: An accepted falling edge of the bus clock, during the preamble or during streaming, sets `bidir_mode_o` = 1 and releases the line.
- R8: Once `bidir_mode_o` = 1 it stays 1 whatever the bus clock does. Only reset restores streaming, which then starts again with the preamble and address 0.
- R9: While `bidir_mode_o` = 1, stream clock edges leave the line released and `write_enable_o` follows the stream clock level (1 = writes allowed). While `bidir_mode_o` = 0, `write_enable_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| stream_clk_i | input | 1 | Stream bit clock; write-enable level after handover |
| bus_scl_i | input | 1 | Bidirectional bus clock; a falling edge triggers the handover |
| rd_addr_o | output | AW | Registered byte address to the array |
| rd_data_i | input | 8 | Byte read from the array at `rd_addr_o` |
| sda_pull_low_o | output | 1 | 1 pulls the open-drain data line low, 0 releases it |
| bidir_mode_o | output | 1 | 1 once the data line has been handed to the two-wire slave |
| write_enable_o | output | 1 | Write permission for the two-wire slave in bidirectional mode |

## Verification
Each test starts from reset and walks the stream through the preamble, every byte of a small array and past the wrap point. The array holds irregular byte values, so a bit-order, off-by-one or wrap fault changes at least one compared slot. Short spikes on each clock input are placed between real edges. On the stream clock a spike must leave the next expected bit unchanged, and on the bus clock it must leave the mode unchanged. This separates a filter that works from one that passes every edge. The handover is triggered once during streaming and once inside the preamble. It is followed by stream clock edges, a return of the bus clock high and a final reset, which tell apart a one-way switch, a stray stream advance and a working reset restart.

// File: rtl/ddc_stream_pkg.sv
package ddc_stream_pkg;
    typedef enum logic [1:0] {
        PH_PREAMBLE = 2'd0,
        PH_STREAM   = 2'd1,
        PH_HANDOVER = 2'd2
    } ddc_phase_e;

    localparam int unsigned PREAMBLE_EDGES = 9;
    localparam int unsigned FRAME_SLOTS    = 9;
    localparam int unsigned NULL_SLOT      = FRAME_SLOTS - 1;
    localparam int unsigned LAST_DATA_SLOT = NULL_SLOT - 1;
endpackage

// File: rtl/ddc_pin_filter.sv
module ddc_pin_filter #(
    parameter int unsigned FILT_CYC = 4,
    parameter logic        RST_LVL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int unsigned CW = $clog2(FILT_CYC + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          level;
        logic [CW-1:0] cnt;
        logic          rise;
        logic          fall;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d      = flt_q;
        flt_d.sync = {flt_q.sync[0], pin_i};
        flt_d.rise = 1'b0;
        flt_d.fall = 1'b0;
        if (flt_q.sync[1] != flt_q.level) begin
            if (flt_q.cnt == CW'(FILT_CYC - 1)) begin
                flt_d.level = flt_q.sync[1];
                flt_d.cnt   = '0;
                flt_d.rise  = flt_q.sync[1];
                flt_d.fall  = !flt_q.sync[1];
            end else begin
                flt_d.cnt = flt_q.cnt + 1'b1;
            end
        end else begin
            flt_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q.sync  <= {RST_LVL, RST_LVL};
            flt_q.level <= RST_LVL;
            flt_q.cnt   <= '0;
            flt_q.rise  <= 1'b0;
            flt_q.fall  <= 1'b0;
        end else begin
            flt_q <= flt_d;
        end
    end

    assign level_o = flt_q.level;
    assign rise_o  = flt_q.rise;
    assign fall_o  = flt_q.fall;

    // R6: the accepted level moves only after a full hold window
    assert_level_needs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_q.level != $past(flt_q.level)) |-> ($past(flt_q.cnt) == CW'(FILT_CYC - 1)));

    // R6: an edge pulse always matches a real change of the accepted level
    assert_edge_matches_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_q.rise || flt_q.fall) |-> (flt_q.level != $past(flt_q.level)));
endmodule

// File: rtl/ddc_stream_seq.sv
module ddc_stream_seq
    import ddc_stream_pkg::*;
#(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned AW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vclk_rise_i,
    input  logic          vclk_level_i,
    input  logic          scl_fall_i,
    input  logic [7:0]    rdata_i,
    output logic [AW-1:0] addr_o,
    output logic          sda_low_o,
    output logic          bidir_o,
    output logic          wen_o
);
    localparam int unsigned PW = $clog2(PREAMBLE_EDGES + 1);
    localparam int unsigned SW = $clog2(FRAME_SLOTS);

    typedef struct packed {
        ddc_phase_e    phase;
        logic [PW-1:0] pre_cnt;
        logic [SW-1:0] slot;
        logic [7:0]    shift;
        logic [AW-1:0] addr;
        logic          low;
        logic          wen;
    } seq_t;

    seq_t          st_d, st_q;
    logic          load;
    logic [AW-1:0] addr_inc;

    always_comb begin
        st_d     = st_q;
        load     = 1'b0;
        addr_inc = (st_q.addr == AW'(DEPTH - 1)) ? '0 : st_q.addr + 1'b1;

        case (st_q.phase)
            PH_PREAMBLE: begin
                if (vclk_rise_i) begin
                    if (st_q.pre_cnt == PW'(PREAMBLE_EDGES)) begin
                        st_d.phase = PH_STREAM;
                        load       = 1'b1;
                    end else begin
                        st_d.pre_cnt = st_q.pre_cnt + 1'b1;
                    end
                end
            end
            PH_STREAM: begin
                if (vclk_rise_i) begin
                    if (st_q.slot == SW'(NULL_SLOT)) begin
                        load = 1'b1;
                    end else if (st_q.slot == SW'(LAST_DATA_SLOT)) begin
                        st_d.low  = 1'b0;
                        st_d.slot = SW'(NULL_SLOT);
                    end else begin
                        st_d.low   = !st_q.shift[7];
                        st_d.shift = {st_q.shift[6:0], 1'b0};
                        st_d.slot  = st_q.slot + 1'b1;
                    end
                end
            end
            default: ;
        endcase

        if (load) begin
            st_d.low   = !rdata_i[7];
            st_d.shift = {rdata_i[6:0], 1'b0};
            st_d.slot  = '0;
            st_d.addr  = addr_inc;
        end

        if (st_q.phase != PH_HANDOVER && scl_fall_i) begin
            st_d.phase = PH_HANDOVER;
            st_d.low   = 1'b0;
        end

        st_d.wen = (st_d.phase == PH_HANDOVER) && vclk_level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase   <= PH_PREAMBLE;
            st_q.pre_cnt <= '0;
            st_q.slot    <= '0;
            st_q.shift   <= '0;
            st_q.addr    <= '0;
            st_q.low     <= 1'b0;
            st_q.wen     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o    = st_q.addr;
    assign sda_low_o = st_q.low;
    assign bidir_o   = (st_q.phase == PH_HANDOVER);
    assign wen_o     = st_q.wen;

    // R2: the line stays released through the preamble
    assert_quiet_preamble_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_PREAMBLE) |-> !st_q.low);

    // R3: the line moves only after an accepted clock edge
    assert_line_moves_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.low) |-> $past(vclk_rise_i || scl_fall_i));

    // R4: the null slot is released
    assert_null_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_STREAM && st_q.slot == SW'(NULL_SLOT)) |-> !st_q.low);

    // R5: the read address stays inside the array
    assert_addr_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.addr) < DEPTH);

    // R7: after handover the line is released
    assert_handover_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_HANDOVER) |-> !st_q.low);

    // R8: the handover is permanent until reset
    assert_one_way_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_HANDOVER) |=> (st_q.phase == PH_HANDOVER));

    // R9: write permission exists only in bidirectional mode
    assert_wen_bidir_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wen |-> (st_q.phase == PH_HANDOVER));
endmodule

// File: rtl/ddc_stream_port.sv
module ddc_stream_port #(
    parameter int unsigned DEPTH    = 128,
    parameter int unsigned FILT_CYC = 4,
    localparam int unsigned AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stream_clk_i,
    input  logic          bus_scl_i,
    output logic [AW-1:0] rd_addr_o,
    input  logic [7:0]    rd_data_i,
    output logic          sda_pull_low_o,
    output logic          bidir_mode_o,
    output logic          write_enable_o
);
    logic vclk_level, vclk_rise, vclk_fall;
    logic scl_level, scl_rise, scl_fall;

    ddc_pin_filter #(.FILT_CYC(FILT_CYC), .RST_LVL(1'b0)) u_vclk_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (stream_clk_i),
        .level_o (vclk_level),
        .rise_o  (vclk_rise),
        .fall_o  (vclk_fall)
    );

    ddc_pin_filter #(.FILT_CYC(FILT_CYC), .RST_LVL(1'b1)) u_scl_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (bus_scl_i),
        .level_o (scl_level),
        .rise_o  (scl_rise),
        .fall_o  (scl_fall)
    );

    ddc_stream_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .vclk_rise_i  (vclk_rise),
        .vclk_level_i (vclk_level),
        .scl_fall_i   (scl_fall),
        .rdata_i      (rd_data_i),
        .addr_o       (rd_addr_o),
        .sda_low_o    (sda_pull_low_o),
        .bidir_o      (bidir_mode_o),
        .wen_o        (write_enable_o)
    );

    // R6: filtered edges of one input never fire together
    assert_vclk_edges_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(vclk_rise && vclk_fall));
    assert_scl_edges_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_rise && scl_fall));

    // R7: a handover follows a filtered bus clock fall to a low level
    assert_handover_on_low_scl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bidir_mode_o) |-> ($past(scl_fall) && !$past(scl_level)));
endmodule

// File: tb/ddc_stream_port_tb.sv
module ddc_stream_port_tb;
    localparam int unsigned DEPTH    = 16;
    localparam int unsigned FILT_CYC = 4;
    localparam int unsigned AW       = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stream_clk = 1'b0;
    logic          bus_scl = 1'b1;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic          sda_low, bidir, wen;

    logic [7:0] mem [DEPTH];
    int vec_cnt = 0;
    int bad_cnt = 0;
    bit done = 1'b0;

    typedef struct {
        bit    exp_low;
        string tag;
    } sb_item_t;
    sb_item_t sb[$];
    event sample_ev;

    always #5 clk = ~clk;

    assign rd_data = mem[rd_addr];

    ddc_stream_port #(.DEPTH(DEPTH), .FILT_CYC(FILT_CYC)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .stream_clk_i   (stream_clk),
        .bus_scl_i      (bus_scl),
        .rd_addr_o      (rd_addr),
        .rd_data_i      (rd_data),
        .sda_pull_low_o (sda_low),
        .bidir_mode_o   (bidir),
        .write_enable_o (wen)
    );

    // monitor: compares the line against the scoreboard at each sample point
    initial begin
        forever begin
            @(sample_ev);
            vec_cnt++;
            if (sb.size() == 0) begin
                bad_cnt++;
                $display("FAIL scoreboard empty: actual sda_low=%0b expected none", sda_low);
            end else begin
                sb_item_t it;
                it = sb.pop_front();
                if (sda_low !== it.exp_low) begin
                    bad_cnt++;
                    $display("FAIL %s: sda_low actual=%0b expected=%0b", it.tag, sda_low, it.exp_low);
                end
            end
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        vec_cnt++;
        if (act !== exp) begin
            bad_cnt++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: one accepted stream clock period, expected line pushed first
    task automatic edge_sample(input bit exp_low, input string tag);
        sb.push_back('{exp_low, tag});
        stream_clk = 1'b1;
        wait_cyc(16);
        ->sample_ev;
        wait_cyc(4);
        stream_clk = 1'b0;
        wait_cyc(20);
    endtask

    // driver: spike shorter than the filter window, then a sample with no edge
    task automatic vclk_spike_sample(input bit exp_low, input string tag);
        stream_clk = 1'b1;
        wait_cyc(2);
        stream_clk = 1'b0;
        wait_cyc(20);
        sb.push_back('{exp_low, tag});
        ->sample_ev;
        wait_cyc(2);
    endtask

    task automatic do_reset();
        stream_clk = 1'b0;
        bus_scl    = 1'b1;
        rst_n      = 1'b0;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
    endtask

    task automatic send_byte(input logic [7:0] b, input string tag);
        for (int k = 7; k >= 0; k--) edge_sample(!b[k], tag);
        edge_sample(1'b0, "R4 null slot");
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'((i * 73 + 11) ^ (i << 4));
        mem[1] = 8'h00;
        mem[5] = 8'hFF;

        // run 1: reset, preamble, full pass with wrap, spikes, handover
        do_reset();
        check(sda_low, 0, "R1 line released");
        check(bidir, 0, "R1 mode");
        check(wen, 0, "R1 write enable");
        check(rd_addr, 0, "R1 address");

        for (int p = 0; p < 9; p++) edge_sample(1'b0, "R2 preamble");

        for (int idx = 0; idx < DEPTH + 2; idx++) begin
            logic [7:0] b;
            b = mem[idx % DEPTH];
            if (idx == 2) begin
                for (int k = 7; k >= 4; k--) edge_sample(!b[k], "R3 data bit");
                vclk_spike_sample(!b[4], "R6 stream spike ignored");
                for (int k = 3; k >= 0; k--) edge_sample(!b[k], "R3 data bit after spike");
                edge_sample(1'b0, "R4 null slot");
            end else begin
                send_byte(b, (idx >= DEPTH) ? "R5 wrapped byte" : "R3 data bit");
            end
        end

        bus_scl = 1'b0;
        wait_cyc(2);
        bus_scl = 1'b1;
        wait_cyc(20);
        check(bidir, 0, "R6 bus clock spike ignored");
        edge_sample(!mem[2][7], "R6 stream continues after bus spike");

        bus_scl = 1'b0;
        wait_cyc(20);
        check(bidir, 1, "R7 handover during stream");
        check(sda_low, 0, "R7 line released");

        stream_clk = 1'b1;
        wait_cyc(20);
        check(sda_low, 0, "R9 stream edge ignored");
        check(wen, 1, "R9 write enable high");
        stream_clk = 1'b0;
        wait_cyc(20);
        check(wen, 0, "R9 write enable low");

        bus_scl = 1'b1;
        wait_cyc(20);
        bus_scl = 1'b0;
        wait_cyc(20);
        bus_scl = 1'b1;
        wait_cyc(20);
        check(bidir, 1, "R8 mode stays after bus activity");
        for (int p = 0; p < 12; p++) edge_sample(1'b0, "R9 no streaming after handover");
        check(bidir, 1, "R8 mode stays after stream edges");

        // run 2: handover inside the preamble
        do_reset();
        check(bidir, 0, "R1 mode after second reset");
        for (int p = 0; p < 3; p++) edge_sample(1'b0, "R2 preamble");
        bus_scl = 1'b0;
        wait_cyc(20);
        check(bidir, 1, "R7 handover during preamble");
        for (int p = 0; p < 9; p++) edge_sample(1'b0, "R7 released after early handover");

        // run 3: reset restores full streaming from address 0
        do_reset();
        check(rd_addr, 0, "R8 address after reset");
        for (int p = 0; p < 9; p++) edge_sample(1'b0, "R2 preamble");
        send_byte(mem[0], "R8 restart at address 0");
        send_byte(mem[1], "R5 ascending order");

        wait_cyc(4);
        check(sb.size(), 0, "scoreboard drained");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad_cnt++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
            $finish;
        end
    end
endmodule